// File: doc/BRIEF.md
# Multichannel Adaptive Sampling Compressor

This block thins out slowly varying biosignal data before it reaches a downstream buffer. Up to four channels share one input stream, with each sample tagged by a channel number. For every enabled channel the block gathers a window of sixteen samples in registers. While the samples arrive it tracks the running maximum and minimum of the window. When the window is full, the spread (maximum minus minimum) is compared with three programmable thresholds. That comparison picks one of four decimation levels. Flat windows keep few samples and busy windows keep all of them.

Finished windows go out on a valid/ready stream. Each window starts with a header word that holds the channel, the chosen level and the measured spread. The kept samples follow in window order. All channels use one min/max comparator, one level selector and one emitter. Enabling more channels adds only window registers. Completed windows are served round-robin in ascending channel order.

Back-pressure rules. An input sample is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only for a channel whose completed window is waiting or being sent, so other channels keep flowing. On the output, a word is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, a pending word is held unchanged.

Top module: `adsamp_comp`

## Requirements
- R1: `in_ready` is low exactly when the channel on `in_chan` holds a completed window that has not yet been fully emitted. A sample is accepted on an edge where `in_valid` and `in_ready` are both high.
- R2: A sample accepted for a channel whose `chan_en` bit is 0 is discarded. It produces no output and does not advance that channel's window.
- R3: Each channel builds its own 16-sample window from its own accepted samples. Samples of different channels may interleave in any order.
- R4: The spread is the largest minus the smallest signed sample of the window, with both reset at the window's first sample. It is reported as an unsigned value in bits 11:0 of the header word.
- R5: Level codes are chosen as follows:
  - code 0 when spread >= `thr_hi`
  - otherwise code 1 when spread >= `thr_mid`
  - otherwise code 2 when spread >= `thr_lo`
  - otherwise code 3
- R6: Level code L emits 16>>L data words after the header. These are the samples at window positions 0, 2^L, 2·2^L, …, in ascending position order.
- R7: The output word has the following fields:
  - bit 16: header flag
  - bits 15:14: channel
  - bits 13:12: level code
  - bits 11:0: sample (or, in a header, the spread)
- R8: Completed windows of enabled channels are served round-robin in ascending channel order, starting after the last channel served. After reset, channel 0 is first in line. When another window is waiting, its header follows the previous window's last data word on the very next cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` does not change.
- R10: After reset, `out_valid` is low, `in_ready` is high and every window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 4 | Per-channel enable |
| thr_lo | input | 12 | Lowest spread threshold |
| thr_mid | input | 12 | Middle spread threshold |
| thr_hi | input | 12 | Highest spread threshold |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample may be taken |
| in_chan | input | 2 | Channel of the input sample |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word may be consumed |
| out_word | output | 17 | Header or kept sample (fields in R7) |

## Verification
The assertions check, on every cycle, that a stalled output word holds still. They also check that every window carries exactly the number of data words its level code promises, that data words never change channel inside a window, and that header levels at both threshold extremes are consistent with the reported spread. Several behaviours can only be shown by the bench's scenarios against its reference model:
- the correct sample positions
- exact threshold boundaries at the middle levels
- the round-robin order with no gap between windows
- discarding of samples for disabled channels
- per-channel input stalls while other channels keep flowing

// File: rtl/adsamp_pkg.sv
package adsamp_pkg;

  // Decimation level codes: keep every 1st, 2nd, 4th or 8th sample.
  typedef enum logic [1:0] {
    LV_FULL   = 2'd0,
    LV_HALF   = 2'd1,
    LV_QTR    = 2'd2,
    LV_EIGHTH = 2'd3
  } lvl_e;

  // Coarser level for smaller spread; thresholds assumed ascending.
  function automatic lvl_e sel_level(input logic [31:0] spread,
                                     input logic [31:0] lo,
                                     input logic [31:0] mid,
                                     input logic [31:0] hi);
    if (spread >= hi)       return LV_FULL;
    else if (spread >= mid) return LV_HALF;
    else if (spread >= lo)  return LV_QTR;
    else                    return LV_EIGHTH;
  endfunction

endpackage

// File: rtl/adsamp_rr.sv
// Rotating priority pick: first requester after 'last', ascending ID.
module adsamp_rr #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  input  logic [CW-1:0]  last,
  output logic           any,
  output logic [CW-1:0]  pick
);

  int c;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    c    = 0;
    // Walk from farthest to nearest so the nearest requester wins.
    for (int k = NCH; k >= 1; k--) begin
      c = (int'(last) + k) % NCH;
      if (req[c]) begin
        any  = 1'b1;
        pick = CW'(c);
      end
    end
  end

endmodule

// File: rtl/adsamp_window.sv
// Per-channel window registers plus one shared min/max/level datapath.
module adsamp_window
  import adsamp_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 12,
  parameter int WIN = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_ch,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  thr_lo,
  input  logic [W-1:0]  thr_mid,
  input  logic [W-1:0]  thr_hi,
  input  logic [CW-1:0] rd_ch,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  rd_spread,
  output logic [1:0]    rd_level,
  output logic          done
);

  logic [W-1:0]        mem [NCH][WIN];
  logic [IW-1:0]       cnt [NCH];
  logic signed [W-1:0] mx  [NCH];
  logic signed [W-1:0] mn  [NCH];
  logic [W-1:0]        spr [NCH];
  lvl_e                lvl [NCH];

  logic signed [W-1:0] smp, nmx, nmn;
  logic [W-1:0]        nspr;
  logic                first;

  // Shared datapath, multiplexed by the channel of the accepted sample.
  always_comb begin
    smp   = $signed(wr_data);
    first = (cnt[wr_ch] == '0);
    nmx   = (first || smp > mx[wr_ch]) ? smp : mx[wr_ch];
    nmn   = (first || smp < mn[wr_ch]) ? smp : mn[wr_ch];
    nspr  = W'(nmx - nmn);   // true difference fits in W unsigned bits
    done  = wr_en && (cnt[wr_ch] == IW'(WIN - 1));
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ch][cnt[wr_ch]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        cnt[c] <= '0;
        mx[c]  <= '0;
        mn[c]  <= '0;
        spr[c] <= '0;
        lvl[c] <= LV_FULL;
      end
    end else if (wr_en) begin
      mx[wr_ch] <= nmx;
      mn[wr_ch] <= nmn;
      if (done) begin
        cnt[wr_ch] <= '0;
        spr[wr_ch] <= nspr;
        lvl[wr_ch] <= sel_level(32'(nspr), 32'(thr_lo), 32'(thr_mid), 32'(thr_hi));
      end else begin
        cnt[wr_ch] <= cnt[wr_ch] + 1'b1;
      end
    end
  end

  assign rd_data   = mem[rd_ch][rd_idx];
  assign rd_spread = spr[rd_ch];
  assign rd_level  = lvl[rd_ch];

endmodule

// File: rtl/adsamp_emit.sv
// Tracks completed windows and streams header plus kept samples.
module adsamp_emit #(
  parameter int NCH = 4,
  parameter int W   = 12,
  parameter int WIN = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW = $clog2(WIN),
  localparam int OW = 1 + CW + 2 + W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic           done,
  input  logic [CW-1:0]  done_ch,
  input  logic           out_ready,
  input  logic [1:0]     level,
  input  logic [W-1:0]   spread,
  input  logic [W-1:0]   rd_data,
  output logic           out_valid,
  output logic [OW-1:0]  out_word,
  output logic [CW-1:0]  rd_ch,
  output logic [IW-1:0]  rd_idx,
  output logic [NCH-1:0] pending
);

  logic          active;
  logic [CW-1:0] cur_ch, rr_last, gnt_ch;
  logic [IW:0]   idx, n_words;
  logic [IW-1:0] dnum;
  logic [NCH-1:0] cur_mask, req;
  logic          fire, finishing, gnt_any, pick_go, is_hdr;

  always_comb begin
    n_words   = (IW + 1)'(WIN) >> level;
    fire      = active && out_ready;
    finishing = fire && (idx == n_words);
    cur_mask  = active ? (NCH'(1) << cur_ch) : '0;
    req       = pending & chan_en & ~cur_mask;
    pick_go   = (!active || finishing) && gnt_any;
    is_hdr    = (idx == '0);
    dnum      = idx[IW-1:0] - 1'b1;
    rd_idx    = dnum << level;
  end

  adsamp_rr #(.NCH(NCH)) rr_i (
    .req  (req),
    .last (rr_last),
    .any  (gnt_any),
    .pick (gnt_ch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cur_ch  <= '0;
      idx     <= '0;
      rr_last <= CW'(NCH - 1);
    end else if (pick_go) begin
      active  <= 1'b1;
      cur_ch  <= gnt_ch;
      idx     <= '0;
      rr_last <= gnt_ch;
    end else if (finishing) begin
      active  <= 1'b0;
    end else if (fire) begin
      idx     <= idx + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n)                              pending[c] <= 1'b0;
      else if (done && done_ch == CW'(c))      pending[c] <= 1'b1;
      else if (finishing && cur_ch == CW'(c))  pending[c] <= 1'b0;
    end
  end

  assign rd_ch     = cur_ch;
  assign out_valid = active;
  assign out_word  = {is_hdr, cur_ch, level, is_hdr ? spread : rd_data};

endmodule

// File: rtl/adsamp_comp.sv
module adsamp_comp #(
  parameter int NCH = 4,
  parameter int W   = 12,
  parameter int WIN = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW = $clog2(WIN),
  localparam int OW = 1 + CW + 2 + W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic [W-1:0]   thr_lo,
  input  logic [W-1:0]   thr_mid,
  input  logic [W-1:0]   thr_hi,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CW-1:0]  in_chan,
  input  logic [W-1:0]   in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OW-1:0]  out_word
);

  logic [NCH-1:0] pending;
  logic           wr_en, done;
  logic [CW-1:0]  rd_ch;
  logic [IW-1:0]  rd_idx;
  logic [W-1:0]   rd_data, rd_spread;
  logic [1:0]     rd_level;

  assign in_ready = !pending[in_chan];
  assign wr_en    = in_valid && in_ready && chan_en[in_chan];

  adsamp_window #(.NCH(NCH), .W(W), .WIN(WIN)) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_ch     (in_chan),
    .wr_data   (in_data),
    .thr_lo    (thr_lo),
    .thr_mid   (thr_mid),
    .thr_hi    (thr_hi),
    .rd_ch     (rd_ch),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_spread (rd_spread),
    .rd_level  (rd_level),
    .done      (done)
  );

  adsamp_emit #(.NCH(NCH), .W(W), .WIN(WIN)) emit_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .done      (done),
    .done_ch   (in_chan),
    .out_ready (out_ready),
    .level     (rd_level),
    .spread    (rd_spread),
    .rd_data   (rd_data),
    .out_valid (out_valid),
    .out_word  (out_word),
    .rd_ch     (rd_ch),
    .rd_idx    (rd_idx),
    .pending   (pending)
  );

endmodule

// File: rtl/adsamp_comp_chk.sv
module adsamp_comp_chk #(
  parameter int NCH = 4,
  parameter int W   = 12,
  parameter int WIN = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IW = $clog2(WIN),
  localparam int OW = 1 + CW + 2 + W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  thr_lo,
  input logic [W-1:0]  thr_hi,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_word
);

  logic          hdr, fire;
  logic [CW-1:0] ch;
  logic [1:0]    lv;
  logic [W-1:0]  dat;
  logic [IW:0]   rem;
  logic [CW-1:0] hch;

  assign hdr  = out_word[OW-1];
  assign ch   = out_word[OW-2 -: CW];
  assign lv   = out_word[W+1:W];
  assign dat  = out_word[W-1:0];
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem <= '0;
      hch <= '0;
    end else if (fire) begin
      if (hdr) begin
        rem <= (IW + 1)'(WIN) >> lv;
        hch <= ch;
      end else begin
        rem <= rem - 1'b1;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R5
  lvl_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && hdr && (dat >= thr_hi) |-> lv == 2'd0);

  // R5
  lvl_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && hdr && (dat < thr_lo) |-> lv == 2'd3);

  // R6
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && hdr |-> rem == '0);

  // R7
  data_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !hdr |-> rem != '0 && ch == hch);

endmodule

bind adsamp_comp adsamp_comp_chk #(.NCH(NCH), .W(W), .WIN(WIN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .thr_lo    (thr_lo),
  .thr_hi    (thr_hi),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word)
);

// File: tb/adsamp_comp_tb_top.sv
module adsamp_comp_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  chan_en;
  logic [11:0] thr_lo, thr_mid, thr_hi;
  logic        in_valid, in_ready;
  logic [1:0]  in_chan;
  logic [11:0] in_data;
  logic        out_valid, out_ready;
  logic [16:0] out_word;

  int  checks = 0;
  int  errors = 0;
  bit  stall_mode = 1'b0;
  int  hcnt [4];

  // Reference model state
  int  mcnt [4];
  int  mwin [4][16];
  bit  mpend [4];
  int  mspr [4];
  int  mlev [4];
  bit  mact;
  int  mch, midx, mrr;

  always #10 clk = ~clk;

  adsamp_comp dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl_of(input int s);
    if (s >= int'(thr_hi))       return 0;
    else if (s >= int'(thr_mid)) return 1;
    else if (s >= int'(thr_lo))  return 2;
    return 3;
  endfunction

  function automatic logic [16:0] exp_word();
    int lev;
    lev = mlev[mch];
    if (midx == 0) return {1'b1, 2'(mch), 2'(lev), 12'(mspr[mch])};
    return {1'b0, 2'(mch), 2'(lev), 12'(mwin[mch][(midx - 1) << lev])};
  endfunction

  // Behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    bit rdy;
    bit free;
    int n, c, mxv, mnv;
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin mcnt[k] = 0; mpend[k] = 0; end
      mact = 0; mch = 0; midx = 0; mrr = 3;
    end else begin
      rdy  = !mpend[in_chan];
      free = !mact;
      if (mact && out_ready) begin
        n = 16 >> mlev[mch];
        if (midx == n) begin
          mpend[mch] = 0; mact = 0; free = 1;
        end else midx++;
      end
      if (free) begin
        for (int k = 1; k <= 4 && !mact; k++) begin
          c = (mrr + k) % 4;
          if (mpend[c] && chan_en[c]) begin
            mact = 1; mch = c; midx = 0; mrr = c;
          end
        end
      end
      if (in_valid && rdy && chan_en[in_chan]) begin
        c = in_chan;
        mwin[c][mcnt[c]] = int'($signed(in_data));
        mcnt[c]++;
        if (mcnt[c] == 16) begin
          mxv = mwin[c][0]; mnv = mwin[c][0];
          for (int k = 1; k < 16; k++) begin
            if (mwin[c][k] > mxv) mxv = mwin[c][k];
            if (mwin[c][k] < mnv) mnv = mwin[c][k];
          end
          mspr[c]  = mxv - mnv;
          mlev[c]  = lvl_of(mspr[c]);
          mpend[c] = 1;
          mcnt[c]  = 0;
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready == !mpend[in_chan], "R1 in_ready", int'(in_ready), int'(!mpend[in_chan]));
      chk(out_valid == mact, "R8 out_valid", int'(out_valid), int'(mact));
      if (mact && out_valid)
        chk(out_word == exp_word(), "R4/R5/R6/R7 out_word", int'(out_word), int'(exp_word()));
      if (out_valid && out_ready && out_word[16]) hcnt[out_word[15:14]]++;
    end
  end

  always @(posedge clk) begin
    #2;
    out_ready = stall_mode ? ($urandom % 4 != 0) : 1'b1;
  end

  // Positions visited in a scrambled order reach both 0 and amp exactly.
  task automatic send(input int ch, input int base, input int amp, input int i);
    @(posedge clk); #2;
    in_valid = 1'b1;
    in_chan  = 2'(ch);
    in_data  = 12'(base + ((i * 5) % 16) * amp / 15);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((mact || mpend[0] || mpend[1] || mpend[2] || mpend[3]) && t < 5000) begin
      @(posedge clk); t++;
    end
    repeat (4) @(posedge clk);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) hcnt[k] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_chan = '0; in_data = '0;
    out_ready = 1'b1; chan_en = 4'b0111;
    thr_lo = 12'd10; thr_mid = 12'd100; thr_hi = 12'd1000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R10 reset out_valid", int'(out_valid), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;

    // R3 interleaved channels with random output stalls (R9); ch3 disabled (R2)
    stall_mode = 1'b1;
    for (int w = 0; w < 3; w++)
      for (int i = 0; i < 16; i++) begin
        send(0, 40, 3, i);       // spread 3    -> level 3
        send(1, -500, 1500, i);  // spread 1500 -> level 0
        send(2, 50, 100, i);     // spread 100 == thr_mid -> level 1
        send(3, 0, 2000, i);     // discarded
      end
    drain();
    chk(hcnt[3] == 0, "R2 disabled channel headers", hcnt[3], 0);
    chk(hcnt[0] == 3, "R8 ch0 windows", hcnt[0], 3);
    chk(hcnt[1] == 3, "R8 ch1 windows", hcnt[1], 3);
    chk(hcnt[2] == 3, "R8 ch2 windows", hcnt[2], 3);

    // R5 threshold boundaries on a single channel; R1 stall on own channel
    stall_mode = 1'b0;
    chan_en = 4'b0001;
    for (int i = 0; i < 16; i++) send(0, -300, 1000, i);
    for (int i = 0; i < 16; i++) send(0, 7, 999, i);
    for (int i = 0; i < 16; i++) send(0, 0, 10, i);
    for (int i = 0; i < 16; i++) send(0, 0, 9, i);
    drain();
    chk(hcnt[0] == 7, "R5 ch0 boundary windows", hcnt[0], 7);

    // R4 full signed range; flat windows on other channels
    chan_en = 4'b1111;
    stall_mode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      send(3, -2048, 4095, i);
      send(1, 5, 0, i);
      send(2, -9, 0, i);
    end
    drain();
    chk(hcnt[3] == 1, "R4 ch3 full range window", hcnt[3], 1);
    chk(hcnt[1] == 4 && hcnt[2] == 4, "R3 ch1/ch2 windows", hcnt[1] + hcnt[2], 8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule